// File: doc/BRIEF.md
# Vector-Forwarding Interrupt Controller

This block gathers 64 interrupt lines and forwards them to a downstream interrupt controller as a stream of events. Each event carries an 8-bit vector and a direction flag: "assert" when a line becomes active and unmasked, "deassert" when a line that was forwarded goes inactive. Each line is set to level or edge mode. It has a mask bit and a programmable vector byte. A request bit records that a line is asking for service. An in-service bit records that an assert was forwarded and has not yet been retracted.

Software reaches the block through a 32-bit register port. Every 64-bit register is seen as two 32-bit words. Edge-mode requests stay set until software writes ones to a clear register. Changing the mask re-evaluates every line whose mask bit flipped, lowest line first. Events leave through a valid/ready handshake, one per cycle at most. A register write that causes events is only acknowledged once those events have been accepted downstream.

Top module: `vfpic_top`

## Requirements
- R1: After reset every stored register reads zero, the request and in-service words read zero, no event is offered and no bus acknowledge is pending.
- R2: Each 64-bit register (mask 0x020, message-enable 0x040, edge 0x060, clear 0x080, request 0x100, in-service 0x120) is two words; address bit 2 set selects bits 63:32, and a write changes only the selected word. Line n maps to bit n.
- R3: In level mode a rising line input sets its request bit and, when unmasked, sets its in-service bit and emits an assert event (evt_assert=1). A falling input clears the request bit and, if the line was in service, emits a deassert event (evt_assert=0) and clears the in-service bit.
- R4: A masked line that rises sets its request bit and emits nothing. Clearing its mask bit while the request bit is set emits an assert event. A falling input emits a deassert for an in-service line even when the line is masked.
- R5: With its bit set to 1 in the edge register, a line ignores a falling input and its request bit stays set. A write to the clear register clears only request bits that are set, in edge mode and written as 1, and each cleared in-service line emits a deassert event.
- R6: Lines whose mask bits change in one write are evaluated in ascending line order, so their events leave lowest line first. Setting the mask bit of a line whose request bit is still set emits nothing.
- R7: The vector table at 0x300 holds one byte per line (address 0x300+n) and is read and written by byte. Every event carries the vector byte of its line.
- R8: The polarity register (0x140) and the two auto-control registers (0x0C0, 0x0E0) read zero whatever is written. The route bytes (0x200+n) read 1 whatever is written.
- R9: The identification register (0x000) reads the IDENT parameter in its lower word. Its upper word holds the version parameter in bits 15:0 and 31 in bits 31:16.
- R10: The access ends with bus_err=1 and changes no state when any of these holds: the offset is undecoded, the address is not aligned to its size (bus_size 0/1/2 = 1/2/4 bytes), bus_size is 3, the access writes the identification, request or in-service register, or it reads the clear register.
- R11: An offered event holds its vector and direction until evt_ready is high. A write is acknowledged only after every event it caused has been accepted. Each acknowledge is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 64 | Interrupt line inputs, active high |
| bus_req | input | 1 | Register access request, held until bus_ack |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address of the access |
| bus_size | input | 2 | Access size code: 0 byte, 1 half, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Error response, valid with bus_ack |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| evt_valid | output | 1 | Event offered downstream |
| evt_ready | input | 1 | Downstream accepts the event |
| evt_vector | output | 8 | Vector of the offered event |
| evt_assert | output | 1 | 1 = assert event, 0 = deassert event |

## Verification
On every cycle the checker confirms three things. An offered event stays fixed while it waits for ready. Acknowledges are single pulses, and an error only appears on an acknowledge. No line is left in service with its request bit clear unless a re-evaluation of that line is still queued, which catches lost deassert events. The directed scenarios show the rest. They check the exact event order after a mask write, the write stall while ready is low, and that a falling edge-mode input is ignored. They also cover the selective effect of the clear register, the constant registers and each error case. These depend on sequences of accesses that a single-cycle property cannot relate.

// File: rtl/vfpic_pkg.sv
package vfpic_pkg;

    // Register base offsets (bytes)
    localparam int A_ID    = 'h000;
    localparam int A_MASK  = 'h020;
    localparam int A_MSGEN = 'h040;
    localparam int A_EDGE  = 'h060;
    localparam int A_CLR   = 'h080;
    localparam int A_AUTO0 = 'h0C0;
    localparam int A_AUTO1 = 'h0E0;
    localparam int A_IRR   = 'h100;
    localparam int A_ISR   = 'h120;
    localparam int A_POL   = 'h140;
    localparam int A_ROUTE = 'h200;
    localparam int A_VEC   = 'h300;

    typedef enum logic [3:0] {
        RG_NONE, RG_ID, RG_MASK, RG_MSGEN, RG_EDGE, RG_CLR, RG_AUTO0,
        RG_AUTO1, RG_IRR, RG_ISR, RG_POL, RG_ROUTE, RG_VEC
    } region_e;

    typedef enum logic [1:0] {
        BS_IDLE, BS_WAIT, BS_DONE
    } bus_st_e;

endpackage

// File: rtl/vfpic_decode.sv
module vfpic_decode
    import vfpic_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              we,
    output region_e           region,
    output logic              hi,
    output logic [5:0]        byte_idx,
    output logic              err
);
    localparam int QW_W = ADDR_W - 3;
    localparam int BK_W = ADDR_W - 6;

    logic [QW_W-1:0] qw;
    logic [BK_W-1:0] bk;
    logic            misalign;
    logic            rd_only;

    assign qw       = addr[ADDR_W-1:3];
    assign bk       = addr[ADDR_W-1:6];
    assign hi       = addr[2];
    assign byte_idx = addr[5:0];

    always_comb begin
        if      (qw == QW_W'(A_ID    >> 3)) region = RG_ID;
        else if (qw == QW_W'(A_MASK  >> 3)) region = RG_MASK;
        else if (qw == QW_W'(A_MSGEN >> 3)) region = RG_MSGEN;
        else if (qw == QW_W'(A_EDGE  >> 3)) region = RG_EDGE;
        else if (qw == QW_W'(A_CLR   >> 3)) region = RG_CLR;
        else if (qw == QW_W'(A_AUTO0 >> 3)) region = RG_AUTO0;
        else if (qw == QW_W'(A_AUTO1 >> 3)) region = RG_AUTO1;
        else if (qw == QW_W'(A_IRR   >> 3)) region = RG_IRR;
        else if (qw == QW_W'(A_ISR   >> 3)) region = RG_ISR;
        else if (qw == QW_W'(A_POL   >> 3)) region = RG_POL;
        else if (bk == BK_W'(A_ROUTE >> 6)) region = RG_ROUTE;
        else if (bk == BK_W'(A_VEC   >> 6)) region = RG_VEC;
        else                                region = RG_NONE;
    end

    always_comb begin
        unique case (size)
            2'd0:    misalign = 1'b0;
            2'd1:    misalign = addr[0];
            2'd2:    misalign = (addr[1:0] != 2'b00);
            default: misalign = 1'b1;
        endcase
    end

    assign rd_only = (region == RG_ID) || (region == RG_IRR) || (region == RG_ISR);
    assign err     = (region == RG_NONE) || misalign || (we && rd_only) ||
                     (!we && region == RG_CLR);

endmodule

// File: rtl/vfpic_pick.sv
module vfpic_pick #(
    parameter int N     = 64,
    localparam int IW   = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vfpic_top.sv
module vfpic_top
    import vfpic_pkg::*;
#(
    parameter int          NUM_LINES = 64,
    parameter int          VEC_W     = 8,
    parameter int          ADDR_W    = 10,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] IDENT     = 32'h7C00_0001,
    parameter logic [15:0] ID_VER    = 16'h0001,
    parameter logic [15:0] ID_FIELD  = 16'd31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [1:0]           bus_size,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic                 bus_ack,
    output logic                 bus_err,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 evt_valid,
    input  logic                 evt_ready,
    output logic [VEC_W-1:0]     evt_vector,
    output logic                 evt_assert
);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int HALF  = NUM_LINES / 2;

    typedef struct packed {
        logic [NUM_LINES-1:0]            irr;
        logic [NUM_LINES-1:0]            isr;
        logic [NUM_LINES-1:0]            mask;
        logic [NUM_LINES-1:0]            edg;
        logic [NUM_LINES-1:0]            msgen;
        logic [NUM_LINES-1:0]            pend;
        logic [NUM_LINES-1:0]            pend_up;
        logic [NUM_LINES-1:0]            wr_pend;
        logic [NUM_LINES-1:0]            line_q;
        logic [NUM_LINES-1:0][VEC_W-1:0] vec;
        logic                            evt_vld;
        logic [VEC_W-1:0]                evt_vec;
        logic                            evt_up;
        bus_st_e                         bst;
        logic                            ack;
        logic                            err;
        logic [DATA_W-1:0]               rdata;
    } state_t;

    state_t q, d;

    region_e           dec_region;
    logic              dec_hi;
    logic [5:0]        dec_idx;
    logic              dec_err;
    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;

    vfpic_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr     (bus_addr),
        .size     (bus_size),
        .we       (bus_we),
        .region   (dec_region),
        .hi       (dec_hi),
        .byte_idx (dec_idx),
        .err      (dec_err)
    );

    vfpic_pick #(.N(NUM_LINES)) u_pick (
        .req   (q.pend),
        .found (pick_found),
        .idx   (pick_idx)
    );

    function automatic logic [NUM_LINES-1:0] put_half(input logic [NUM_LINES-1:0] cur,
                                                      input logic hi,
                                                      input logic [DATA_W-1:0] v);
        logic [NUM_LINES-1:0] r;
        r = cur;
        if (hi) r[NUM_LINES-1:HALF] = v[HALF-1:0];
        else    r[HALF-1:0]         = v[HALF-1:0];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] get_half(input logic [NUM_LINES-1:0] cur,
                                                   input logic hi);
        return hi ? DATA_W'(cur[NUM_LINES-1:HALF]) : DATA_W'(cur[HALF-1:0]);
    endfunction

    always_comb begin : p_next
        logic [NUM_LINES-1:0] rise, fall, unmask, remask, clr, new_wr, new_mask;
        logic [DATA_W-1:0]    rd_val;
        logic                 eng_go;

        d        = q;
        d.ack    = 1'b0;
        d.err    = 1'b0;
        d.line_q = line_in;
        new_wr   = '0;
        unmask   = '0;
        remask   = '0;
        clr      = '0;
        new_mask = q.mask;

        // forwarding engine: one line per cycle, lowest first
        if (q.evt_vld && evt_ready) d.evt_vld = 1'b0;
        eng_go = pick_found && (!q.evt_vld || evt_ready);
        if (eng_go) begin
            d.pend[pick_idx] = 1'b0;
            if (q.pend_up[pick_idx] && q.irr[pick_idx] && !q.mask[pick_idx]) begin
                d.isr[pick_idx] = 1'b1;
                d.evt_vld       = 1'b1;
                d.evt_vec       = q.vec[pick_idx];
                d.evt_up        = 1'b1;
            end else if (q.isr[pick_idx] && !q.irr[pick_idx]) begin
                d.isr[pick_idx] = 1'b0;
                d.evt_vld       = 1'b1;
                d.evt_vec       = q.vec[pick_idx];
                d.evt_up        = 1'b0;
            end
        end

        // line inputs
        rise      = line_in & ~q.line_q;
        fall      = ~line_in & q.line_q & ~q.edg;
        d.irr     = (q.irr | rise) & ~fall;
        d.pend    = d.pend | rise | fall;
        d.pend_up = (q.pend_up | rise) & ~fall;

        // read mux
        unique case (dec_region)
            RG_ID:    rd_val = dec_hi ? {ID_FIELD, ID_VER} : IDENT;
            RG_MASK:  rd_val = get_half(q.mask, dec_hi);
            RG_MSGEN: rd_val = get_half(q.msgen, dec_hi);
            RG_EDGE:  rd_val = get_half(q.edg, dec_hi);
            RG_IRR:   rd_val = get_half(q.irr, dec_hi);
            RG_ISR:   rd_val = get_half(q.isr, dec_hi);
            RG_ROUTE: rd_val = DATA_W'(1);
            RG_VEC:   rd_val = DATA_W'(q.vec[dec_idx]);
            default:  rd_val = '0;
        endcase

        // register port
        unique case (q.bst)
            BS_IDLE: begin
                if (bus_req) begin
                    if (dec_err) begin
                        d.ack   = 1'b1;
                        d.err   = 1'b1;
                        d.rdata = '0;
                        d.bst   = BS_DONE;
                    end else if (!bus_we) begin
                        d.ack   = 1'b1;
                        d.rdata = rd_val;
                        d.bst   = BS_DONE;
                    end else begin
                        d.rdata = '0;
                        d.bst   = BS_WAIT;
                        unique case (dec_region)
                            RG_MASK: begin
                                new_mask = put_half(q.mask, dec_hi, bus_wdata);
                                unmask   = q.mask & ~new_mask;
                                remask   = ~q.mask & new_mask;
                                d.mask   = new_mask;
                            end
                            RG_MSGEN: d.msgen = put_half(q.msgen, dec_hi, bus_wdata);
                            RG_EDGE:  d.edg   = put_half(q.edg, dec_hi, bus_wdata);
                            RG_CLR:   clr     = q.irr & q.edg & put_half('0, dec_hi, bus_wdata);
                            RG_VEC:   d.vec[dec_idx] = bus_wdata[VEC_W-1:0];
                            default: ; // constant registers keep no state
                        endcase
                        d.irr     = d.irr & ~clr;
                        new_wr    = unmask | remask | clr;
                        d.pend    = d.pend | new_wr;
                        d.pend_up = (d.pend_up | unmask) & ~remask & ~clr;
                    end
                end
            end
            BS_WAIT: begin
                if (q.wr_pend == '0 && !q.evt_vld) begin
                    d.ack = 1'b1;
                    d.bst = BS_DONE;
                end
            end
            default: d.bst = BS_IDLE;
        endcase

        d.wr_pend = (q.wr_pend | new_wr) & d.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_ack    = q.ack;
    assign bus_err    = q.err;
    assign bus_rdata  = q.rdata;
    assign evt_valid  = q.evt_vld;
    assign evt_vector = q.evt_vec;
    assign evt_assert = q.evt_up;

endmodule

// File: rtl/vfpic_chk.sv
module vfpic_chk #(
    parameter int NUM_LINES = 64,
    parameter int VEC_W     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 evt_valid,
    input logic                 evt_ready,
    input logic [VEC_W-1:0]     evt_vector,
    input logic                 evt_assert,
    input logic                 bus_ack,
    input logic                 bus_err,
    input logic [NUM_LINES-1:0] irr,
    input logic [NUM_LINES-1:0] isr,
    input logic [NUM_LINES-1:0] pend
);
    // R11: an offered event waits unchanged for ready
    p_evt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !evt_ready |=> evt_valid && $stable(evt_vector) && $stable(evt_assert));

    // R11: acknowledge is a single-cycle pulse
    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R10: error only accompanies an acknowledge
    p_err_on_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ack);

    // R3: an in-service line with no request always has a re-evaluation queued
    p_no_stale_service_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((isr & ~irr & ~pend) == '0));

    // R1: nothing offered while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!evt_valid && !bus_ack);
        end
    end
endmodule

bind vfpic_top vfpic_chk #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .evt_ready  (evt_ready),
    .evt_vector (evt_vector),
    .evt_assert (evt_assert),
    .bus_ack    (bus_ack),
    .bus_err    (bus_err),
    .irr        (q.irr),
    .isr        (q.isr),
    .pend       (q.pend)
);

// File: tb/vfpic_top_tb_top.sv
module vfpic_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] line_in = '0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack, bus_err;
    logic [31:0] bus_rdata;
    logic        evt_valid;
    logic        evt_ready = 1'b1;
    logic [7:0]  evt_vector;
    logic        evt_assert;

    int n_chk = 0;
    int n_fail = 0;
    int n_evt = 0;
    logic [7:0] log_vec [0:255];
    logic       log_up  [0:255];
    logic       wr_done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    vfpic_top dut_i (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_vector(evt_vector),
        .evt_assert(evt_assert)
    );

    always @(negedge clk) begin
        if (rst_n && evt_valid && evt_ready && n_evt < 256) begin
            log_vec[n_evt] = evt_vector;
            log_up[n_evt]  = evt_assert;
            n_evt++;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [9:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd, output logic er);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
        @(negedge clk);
        while (!bus_ack) @(negedge clk);
        rd = bus_rdata; er = bus_err;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] wd);
        logic [31:0] rd; logic er;
        access(1'b1, a, 2'd2, wd, rd, er);
        check(!er, "R10 valid write errored", er, 0);
    endtask

    task automatic rd_chk(input logic [9:0] a, input logic [1:0] sz, input logic [31:0] exp,
                          input string tag);
        logic [31:0] rd; logic er;
        access(1'b0, a, sz, '0, rd, er);
        check(!er && rd == exp, tag, rd, exp);
    endtask

    task automatic evt_chk(input int i, input logic [7:0] v, input logic up, input string tag);
        check(n_evt > i && log_vec[i] == v && log_up[i] == up, tag,
              (n_evt > i) ? {log_up[i], log_vec[i]} : 9'h1FF, {up, v});
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        check(!evt_valid && !bus_ack, "R1 idle outputs", {evt_valid, bus_ack}, 0);
        rd_chk(10'h020, 2'd2, 32'h0, "R1 mask zero");
        rd_chk(10'h064, 2'd2, 32'h0, "R1 edge zero");
        rd_chk(10'h100, 2'd2, 32'h0, "R1 request zero");
        rd_chk(10'h124, 2'd2, 32'h0, "R1 in-service zero");
        check(n_evt == 0, "R1 no events", n_evt, 0);
    endtask

    task automatic t_ident();
        rd_chk(10'h000, 2'd2, 32'h7C00_0001, "R9 ident low");
        rd_chk(10'h004, 2'd2, 32'h001F_0001, "R9 ident high");
    endtask

    task automatic t_vectors();
        logic [31:0] rd; logic er;
        for (int i = 0; i < 16; i++) access(1'b1, 10'h300 + 10'(i), 2'd0, 32'h40 + i, rd, er);
        access(1'b1, 10'h300 + 10'd40, 2'd0, 32'h68, rd, er);
        rd_chk(10'h305, 2'd0, 32'h45, "R7 vector byte read");
        rd_chk(10'h328, 2'd0, 32'h68, "R7 vector byte line 40");
    endtask

    task automatic t_halves();
        int n0 = n_evt;
        wr(10'h020, 32'hA5A5_0000);
        wr(10'h024, 32'h0000_1234);
        rd_chk(10'h020, 2'd2, 32'hA5A5_0000, "R2 mask low kept");
        rd_chk(10'h024, 2'd2, 32'h0000_1234, "R2 mask high");
        wr(10'h044, 32'hDEAD_BEEF);
        rd_chk(10'h040, 2'd2, 32'h0, "R2 msgen low untouched");
        rd_chk(10'h044, 2'd2, 32'hDEAD_BEEF, "R2 msgen high");
        wr(10'h024, 32'h0); wr(10'h020, 32'h0);
        check(n_evt == n0, "R2 mask change without requests emits nothing", n_evt - n0, 0);
        n0 = n_evt;
        @(negedge clk) line_in[40] = 1'b1;
        settle();
        evt_chk(n0, 8'h68, 1'b1, "R2 upper line assert");
        rd_chk(10'h124, 2'd2, 32'h100, "R2 in-service upper word");
        @(negedge clk) line_in[40] = 1'b0;
        settle();
        evt_chk(n0 + 1, 8'h68, 1'b0, "R2 upper line deassert");
    endtask

    task automatic t_level();
        int n0 = n_evt;
        @(negedge clk) line_in[2] = 1'b1;
        settle();
        evt_chk(n0, 8'h42, 1'b1, "R3 level assert");
        rd_chk(10'h120, 2'd2, 32'h4, "R3 in-service set");
        @(negedge clk) line_in[2] = 1'b0;
        settle();
        evt_chk(n0 + 1, 8'h42, 1'b0, "R3 level deassert");
        rd_chk(10'h100, 2'd2, 32'h0, "R3 request cleared");
        rd_chk(10'h120, 2'd2, 32'h0, "R3 in-service cleared");
    endtask

    task automatic t_mask();
        int n0;
        wr(10'h020, 32'h8);
        n0 = n_evt;
        @(negedge clk) line_in[3] = 1'b1;
        settle();
        check(n_evt == n0, "R4 masked line silent", n_evt - n0, 0);
        rd_chk(10'h100, 2'd2, 32'h8, "R4 masked request set");
        wr(10'h020, 32'h0);
        evt_chk(n0, 8'h43, 1'b1, "R4 unmask asserts before ack");
        wr(10'h020, 32'h8);
        @(negedge clk) line_in[3] = 1'b0;
        settle();
        evt_chk(n0 + 1, 8'h43, 1'b0, "R4 deassert while masked");
        wr(10'h020, 32'h0);
    endtask

    task automatic t_order();
        int n0;
        wr(10'h020, 32'h16);
        n0 = n_evt;
        @(negedge clk) begin line_in[1] = 1'b1; line_in[2] = 1'b1; line_in[4] = 1'b1; end
        settle();
        check(n_evt == n0, "R6 all masked silent", n_evt - n0, 0);
        wr(10'h020, 32'h0);
        evt_chk(n0,     8'h41, 1'b1, "R6 first line 1");
        evt_chk(n0 + 1, 8'h42, 1'b1, "R6 then line 2");
        evt_chk(n0 + 2, 8'h44, 1'b1, "R6 then line 4");
        wr(10'h020, 32'h16);
        settle();
        check(n_evt == n0 + 3, "R6 remask with request set silent", n_evt - n0, 3);
        @(negedge clk) begin line_in[1] = 1'b0; line_in[2] = 1'b0; line_in[4] = 1'b0; end
        settle();
        evt_chk(n0 + 3, 8'h41, 1'b0, "R6 deassert order 1");
        evt_chk(n0 + 5, 8'h44, 1'b0, "R6 deassert order 4");
        wr(10'h020, 32'h0);
    endtask

    task automatic t_edge();
        int n0;
        wr(10'h060, 32'h20);
        rd_chk(10'h060, 2'd2, 32'h20, "R5 edge readback");
        n0 = n_evt;
        @(negedge clk) begin line_in[5] = 1'b1; line_in[6] = 1'b1; end
        settle();
        evt_chk(n0,     8'h45, 1'b1, "R5 edge line assert");
        evt_chk(n0 + 1, 8'h46, 1'b1, "R5 level line assert");
        @(negedge clk) line_in[5] = 1'b0;
        settle();
        check(n_evt == n0 + 2, "R5 edge fall ignored", n_evt - n0, 2);
        rd_chk(10'h100, 2'd2, 32'h60, "R5 edge request held");
        wr(10'h080, 32'h61);
        evt_chk(n0 + 2, 8'h45, 1'b1 ^ 1'b1, "R5 clear deasserts edge line");
        rd_chk(10'h100, 2'd2, 32'h40, "R5 clear spares level line");
        check(n_evt == n0 + 3, "R5 clear emits one event", n_evt - n0, 3);
        @(negedge clk) line_in[6] = 1'b0;
        settle();
        evt_chk(n0 + 3, 8'h46, 1'b0, "R5 level line deassert");
        wr(10'h060, 32'h0);
    endtask

    task automatic t_const();
        logic [31:0] rd; logic er;
        wr(10'h140, 32'hFFFF_FFFF);
        rd_chk(10'h140, 2'd2, 32'h0, "R8 polarity zero");
        wr(10'h0E4, 32'h1234_5678);
        rd_chk(10'h0E4, 2'd2, 32'h0, "R8 auto-control zero");
        access(1'b1, 10'h205, 2'd0, 32'h0, rd, er);
        rd_chk(10'h205, 2'd0, 32'h1, "R8 route byte one");
    endtask

    task automatic t_errors();
        logic [31:0] rd; logic er;
        access(1'b0, 10'h3F0, 2'd2, 0, rd, er);
        check(er, "R10 undecoded read", er, 1);
        access(1'b1, 10'h022, 2'd2, 32'hFFFF, rd, er);
        check(er, "R10 misaligned write", er, 1);
        rd_chk(10'h020, 2'd2, 32'h0, "R10 misaligned write left mask");
        access(1'b0, 10'h080, 2'd2, 0, rd, er);
        check(er, "R10 read of clear", er, 1);
        access(1'b1, 10'h000, 2'd2, 32'h1, rd, er);
        check(er, "R10 write of ident", er, 1);
        access(1'b0, 10'h020, 2'd3, 0, rd, er);
        check(er, "R10 size code 3", er, 1);
    endtask

    task automatic bg_write(input logic [9:0] a, input logic [31:0] wd);
        logic [31:0] rd; logic er;
        access(1'b1, a, 2'd2, wd, rd, er);
        wr_done = 1'b1;
    endtask

    task automatic t_stall();
        int n0;
        logic [7:0] v0;
        wr(10'h020, 32'h200);
        @(negedge clk) line_in[9] = 1'b1;
        settle();
        evt_ready = 1'b0;
        n0 = n_evt;
        wr_done = 1'b0;
        fork
            bg_write(10'h020, 32'h0);
        join_none
        repeat (8) @(negedge clk);
        check(!wr_done, "R11 write held while ready low", wr_done, 0);
        check(evt_valid && evt_vector == 8'h49 && evt_assert, "R11 event offered",
              {evt_valid, evt_assert, evt_vector}, {2'b11, 8'h49});
        v0 = evt_vector;
        repeat (4) @(negedge clk);
        check(evt_valid && evt_vector == v0, "R11 event held", evt_vector, v0);
        evt_ready = 1'b1;
        repeat (8) @(negedge clk);
        check(wr_done, "R11 write acknowledged after accept", wr_done, 1);
        evt_chk(n0, 8'h49, 1'b1, "R11 accepted event logged");
        @(negedge clk) line_in[9] = 1'b0;
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_ident();
        t_vectors();
        t_halves();
        t_level();
        t_mask();
        t_order();
        t_edge();
        t_const();
        t_errors();
        t_stall();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule